// File: doc/BRIEF.md
# Data and Clock Recovery

This block sits behind a demodulator that delivers a raw, oversampled bit stream. It cleans up the stream and regenerates a bit clock from it. Each input sample passes through a short majority-vote filter, so that isolated one-sample spikes never reach the output. Every level change that survives the filter re-aligns a bit-phase counter, so the decision point stays near the middle of each bit. Between level changes the counter runs freely at the nominal bit period given by `samplesPerBit`.

The recovered data bit changes only when the recovered clock falls. The clock then rises half a bit later, so a downstream consumer can capture the data on the rising edge of the recovered clock. When `recDisable` is high, the block steps aside: the recovered clock is forced low and the data output shows the raw demodulator bit with no delay. Normal operation uses `recDisable` low.

Top module: `bit_recovery`

## Requirements
- R1: While reset is asserted, `recData` and `recClk` are 0. After reset with `recDisable` low and a steady input, `recClk` starts toggling within two bit periods.
- R2: While `recDisable` is 1, `recClk` is 0 and `recData` equals `rawBit` in the same cycle.
- R3: A level that differs from its neighbours for a single sample never changes `recData`, and it does not move the rising edges of `recClk`. This holds both on a steady input and inside a data frame.
- R4: The filtered level takes a new value only when that value is present in at least two of the last three input samples.
- R5: `recData` never changes on the same sample-clock edge on which `recClk` rises. Data changes only where the clock falls.
- R6: A clean frame sent at any `samplesPerBit` from 4 to 255, odd or even, is recovered bit for bit. The frame is 16 alternating bits, then the 8-bit word 0xD3, then the payload, all sent most significant bit first.
- R7: Let an input edge be driven before sample-clock edge 1, with half = floor(`samplesPerBit`/2). Then `recClk` is 1 after edge 3. It stays 1 and `recData` keeps its old value through edge half+2. At edge half+3, `recData` takes the new level and `recClk` falls.
- R8: With no input transitions, `recClk` rises exactly every `samplesPerBit` sample-clock cycles.
- R9: A frame whose bit lengths cycle through `samplesPerBit`+1, `samplesPerBit`-1 and `samplesPerBit` is recovered bit for bit.
- R10: After `recDisable` returns to 0, a following frame is recovered bit for bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; one raw sample per rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| rawBit | input | 1 | Raw bit from the demodulator |
| recDisable | input | 1 | 1 selects pass-through of the raw bit and holds the clock low |
| samplesPerBit | input | CNT_W (8) | Nominal bit period in sample-clock cycles, at least 4 |
| recData | output | 1 | Recovered NRZ data, or the raw bit in pass-through |
| recClk | output | 1 | Recovered bit clock; data is valid at its rising edge |

## Verification
A bit-phase counter that loses its alignment to the input edges shows up first as a wrong delay from an input edge to the data update. That delay is fixed at half+3 cycles, so the error is visible within one bit period. A counter that has slipped without re-aligning instead shifts the data decision toward a bit boundary, and it corrupts recovered frame bits within a few bits of a run of equal values. A filter stage holding a stale or wrong level either lets a single-sample spike through to `recData` one bit period later, or stops a true edge from re-centring the clock. A clock register out of step with the data register breaks the rule that the data must not change when the clock rises, and this shows on the very edge where it happens.

// File: rtl/bit_recovery_pkg.sv
package bit_recovery_pkg;

  // Strobes sent by the phase control to the datapath, one cycle wide each.
  typedef struct packed {
    logic sampleNow;   // take the filtered level into the data register, clock goes low
    logic boundary;    // a bit boundary: the recovered clock goes high
  } recStrobe_t;

endpackage

// File: rtl/bit_recovery_dp.sv
module bit_recovery_dp
  import bit_recovery_pkg::*;
#(
  parameter int VOTE_N = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rawBit,
  input  logic       recDisable,
  input  recStrobe_t strobe,
  output logic       edgeSeen,
  output logic       filtBit,
  output logic       recData,
  output logic       recClk
);

  localparam int VOTE_HALF = VOTE_N / 2;

  logic [VOTE_N-1:0] tapReg;
  logic              voteBit;
  logic              dataReg;
  logic              clkReg;

  // Sample delay line feeding the vote.
  generate
    for (genvar g = 0; g < VOTE_N; g++) begin : gTap
      if (g == 0) begin : gHead
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) tapReg[0] <= 1'b0;
          else       tapReg[0] <= rawBit;
        end
      end else begin : gBody
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) tapReg[g] <= 1'b0;
          else       tapReg[g] <= tapReg[g-1];
        end
      end
    end
  endgenerate

  always_comb voteBit = ($countones(tapReg) > VOTE_HALF);

  // Filtered level; a disagreement with the fresh vote marks an edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) filtBit <= 1'b0;
    else       filtBit <= voteBit;
  end

  always_comb edgeSeen = (voteBit != filtBit);

  // Data register updates only at the mid-bit strobe.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 dataReg <= 1'b0;
    else if (strobe.sampleNow) dataReg <= filtBit;
  end

  // Clock register: high from the bit boundary to mid-bit, low after it.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 clkReg <= 1'b0;
    else if (strobe.boundary)  clkReg <= 1'b1;
    else if (strobe.sampleNow) clkReg <= 1'b0;
  end

  // Pass-through selection at the outputs.
  always_comb begin
    recData = recDisable ? rawBit : dataReg;
    recClk  = clkReg & ~recDisable;
  end

endmodule

// File: rtl/bit_recovery_ctl.sv
module bit_recovery_ctl
  import bit_recovery_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] samplesPerBit,
  input  logic             edgeSeen,
  output recStrobe_t       strobe,
  output logic [CNT_W-1:0] phase
);

  localparam logic [CNT_W-1:0] PH_ONE = CNT_W'(1);

  logic [CNT_W-1:0] midPoint;
  logic [CNT_W-1:0] lastIdx;
  logic             atWrap;
  logic [CNT_W-1:0] phaseNext;

  always_comb begin
    midPoint = samplesPerBit >> 1;
    lastIdx  = samplesPerBit - PH_ONE;
    atWrap   = (phase >= lastIdx);
  end

  // An edge is phase zero of a new bit, so the next count is one.
  always_comb begin
    if (edgeSeen)    phaseNext = PH_ONE;
    else if (atWrap) phaseNext = '0;
    else             phaseNext = phase + PH_ONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= '0;
    else       phase <= phaseNext;
  end

  // A sample that coincides with an edge is dropped so that data never
  // moves on the edge where the clock rises.
  always_comb begin
    strobe.boundary  = edgeSeen | atWrap;
    strobe.sampleNow = (phase == midPoint) & ~edgeSeen;
  end

endmodule

// File: rtl/bit_recovery.sv
module bit_recovery
  import bit_recovery_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int VOTE_N = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rawBit,
  input  logic             recDisable,
  input  logic [CNT_W-1:0] samplesPerBit,
  output logic             recData,
  output logic             recClk
);

  recStrobe_t       strobe;
  logic             edgeSeen;
  logic             filtBit;
  logic [CNT_W-1:0] phase;

  bit_recovery_ctl #(.CNT_W(CNT_W)) uCtl (
    .clk           (clk),
    .rstN          (rstN),
    .samplesPerBit (samplesPerBit),
    .edgeSeen      (edgeSeen),
    .strobe        (strobe),
    .phase         (phase)
  );

  bit_recovery_dp #(.VOTE_N(VOTE_N)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .rawBit     (rawBit),
    .recDisable (recDisable),
    .strobe     (strobe),
    .edgeSeen   (edgeSeen),
    .filtBit    (filtBit),
    .recData    (recData),
    .recClk     (recClk)
  );

endmodule

// File: rtl/bit_recovery_chk.sv
module bit_recovery_chk #(
  parameter int CNT_W  = 8,
  parameter int VOTE_N = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             rawBit,
  input logic             recDisable,
  input logic             recData,
  input logic             recClk,
  input logic             edgeSeen,
  input logic             filtBit,
  input logic [CNT_W-1:0] phase
);

  // Cycles since reset, saturating, to keep $past inside the reset window.
  logic [2:0] cycCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cycCnt <= 3'd0;
    else if (cycCnt != 3'd7)  cycCnt <= cycCnt + 3'd1;
  end

  // R2: pass-through keeps the clock low
  a_r2_bypass_clk_low: assert property (@(posedge clk) disable iff (!rstN)
    recDisable |-> !recClk);

  // R5: data holds on the edge where the clock rises
  a_r5_data_stable_at_rise: assert property (@(posedge clk) disable iff (!rstN)
    (!recDisable && $past(!recDisable) && $rose(recClk)) |-> $stable(recData));

  // R7: an edge restarts the bit phase
  a_r7_edge_recentres: assert property (@(posedge clk) disable iff (!rstN)
    edgeSeen |=> (phase == CNT_W'(1)));

  generate
    if (VOTE_N == 3) begin : gVote3
      // R4: a filtered change is backed by two of the last three samples
      a_r4_vote_backed: assert property (@(posedge clk) disable iff (!rstN)
        (cycCnt >= 3'd5 && filtBit != $past(filtBit)) |->
        (filtBit ? ($countones({$past(rawBit,2), $past(rawBit,3), $past(rawBit,4)}) >= 2)
                 : ($countones({$past(rawBit,2), $past(rawBit,3), $past(rawBit,4)}) <= 1)));
    end
  endgenerate

endmodule

bind bit_recovery bit_recovery_chk #(.CNT_W(CNT_W), .VOTE_N(VOTE_N)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .rawBit     (rawBit),
  .recDisable (recDisable),
  .recData    (recData),
  .recClk     (recClk),
  .edgeSeen   (edgeSeen),
  .filtBit    (filtBit),
  .phase      (phase)
);

// File: tb/sim_bit_recovery.sv
`timescale 1ns/1ps
module sim_bit_recovery;

  localparam logic [7:0] SYNC_WORD = 8'hD3;

  logic       clk = 1'b0;
  logic       rstN;
  logic       rawBit;
  logic       recDisable;
  logic [7:0] samplesPerBit;
  logic       recData;
  logic       recClk;

  int nChecks = 0;
  int nFails  = 0;

  bit         expQ[$];
  bit         hunting = 1'b1;
  string      curReq = "R6";
  logic [7:0] hist = '0;
  bit         prevClk = 1'b0;
  bit         prevData = 1'b0;
  bit         prevDis = 1'b0;

  always #2 clk = ~clk;

  bit_recovery u0 (
    .clk           (clk),
    .rstN          (rstN),
    .rawBit        (rawBit),
    .recDisable    (recDisable),
    .samplesPerBit (samplesPerBit),
    .recData       (recData),
    .recClk        (recClk)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  // Monitor: samples 1 ns after each falling edge, pops expected bits.
  always begin
    @(negedge clk);
    #1;
    if (rstN) begin
      if (!prevClk && recClk) begin
        if (!prevDis && !recDisable)
          check(recData == prevData, "R5", recData, prevData);
        hist = {hist[6:0], recData};
        if (hunting) begin
          if (hist == SYNC_WORD) hunting = 1'b0;
        end else if (expQ.size() > 0) begin
          bit e;
          e = expQ.pop_front();
          check(recData == e, curReq, recData, e);
        end
      end
      prevClk  = recClk;
      prevData = recData;
      prevDis  = recDisable;
    end
  end

  function automatic int bitLen(input int spb, input bit jitter, input int idx);
    if (!jitter)        return spb;
    if (idx % 3 == 0)   return spb + 1;
    if (idx % 3 == 1)   return spb - 1;
    return spb;
  endfunction

  task automatic sendBit(input bit b, input int len, input int glitchAt);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rawBit = (i == glitchAt) ? ~b : b;
    end
  endtask

  task automatic sendFrame(input int spb, input bit jitter, input int glitchAt,
                           input string req, input logic [31:0] payload);
    int idx = 0;
    samplesPerBit = 8'(spb);
    curReq  = req;
    hunting = 1'b1;
    for (int i = 0; i < 16; i++) begin
      sendBit((i % 2) == 0, bitLen(spb, jitter, idx), glitchAt);
      idx++;
    end
    for (int i = 7; i >= 0; i--) begin
      sendBit(SYNC_WORD[i], bitLen(spb, jitter, idx), glitchAt);
      idx++;
    end
    for (int i = 31; i >= 0; i--) begin
      expQ.push_back(payload[i]);
      sendBit(payload[i], bitLen(spb, jitter, idx), glitchAt);
      idx++;
    end
    for (int i = 0; i < 3; i++) begin
      sendBit(i[0], bitLen(spb, jitter, idx), -1);
      idx++;
    end
    repeat (3 * spb) @(negedge clk);
    #1;
    check(expQ.size() == 0, req, expQ.size(), 0);
    check(!hunting, req, int'(hunting), 0);
    expQ.delete();
  endtask

  // Waits for a rising recClk, then counts cycles to the next one.
  task automatic measurePeriod(input int spb, input string req);
    bit pc;
    int n = 0;
    int gap = 0;
    bit seen = 1'b0;
    pc = recClk;
    while (n < 4 * spb) begin
      @(negedge clk); #1;
      n++;
      if (!pc && recClk) begin
        if (seen) begin
          check(gap == spb, req, gap, spb);
          n = 4 * spb;
        end
        seen = 1'b1;
        gap = 0;
      end
      gap++;
      pc = recClk;
    end
  endtask

  initial begin
    #600000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual 1 expected 0");
    finishRun();
  end

  initial begin
    rstN = 1'b0;
    rawBit = 1'b0;
    recDisable = 1'b0;
    samplesPerBit = 8'd16;

    // R1: outputs low in reset, clock starts afterwards
    repeat (4) @(negedge clk);
    #1;
    check(recData == 1'b0, "R1", recData, 0);
    check(recClk == 1'b0, "R1", recClk, 0);
    @(negedge clk);
    rstN = 1'b1;
    begin
      bit rose = 1'b0;
      bit pc = 1'b0;
      bit dataBad = 1'b0;
      for (int i = 0; i < 32; i++) begin
        @(negedge clk); #1;
        if (!pc && recClk) rose = 1'b1;
        if (recData != 1'b0) dataBad = 1'b1;
        pc = recClk;
      end
      check(rose, "R1", rose, 1);
      check(!dataBad, "R1", dataBad, 0);
    end

    // R7: fixed delay from an input edge to clock and data
    repeat (80) @(negedge clk);
    rawBit = 1'b1;
    for (int k = 1; k <= 11; k++) begin
      @(negedge clk); #1;
      if (k == 3)  check(recClk == 1'b1, "R7", recClk, 1);
      if (k == 10) begin
        check(recClk == 1'b1, "R7", recClk, 1);
        check(recData == 1'b0, "R7", recData, 0);
      end
      if (k == 11) begin
        check(recClk == 1'b0, "R7", recClk, 0);
        check(recData == 1'b1, "R7", recData, 1);
      end
    end

    // R8: free-running period at 16
    measurePeriod(16, "R8");
    measurePeriod(16, "R8");

    // R3: isolated one-sample spike on a steady high input
    begin
      bit pc;
      int nRise = 0;
      bit dataBad = 1'b0;
      bit offGrid = 1'b0;
      pc = recClk;
      while (!( !pc && recClk)) begin
        pc = recClk;
        @(negedge clk); #1;
      end
      pc = recClk;
      for (int n = 1; n <= 48; n++) begin
        @(negedge clk);
        rawBit = (n == 3) ? 1'b0 : 1'b1;
        #1;
        if (!pc && recClk) begin
          nRise++;
          if (n % 16 != 0) offGrid = 1'b1;
        end
        if (recData != 1'b1) dataBad = 1'b1;
        pc = recClk;
      end
      check(!dataBad, "R3", dataBad, 0);
      check(!offGrid, "R3", offGrid, 0);
      check(nRise == 3, "R3", nRise, 3);
    end

    // R6: clean frames, even and odd bit periods
    sendFrame(16, 1'b0, -1, "R6", 32'hA5C3_0FF0);
    sendFrame(9, 1'b0, -1, "R6", 32'h3C96_E101);
    sendFrame(4, 1'b0, -1, "R6", 32'h5A0F_F00D);

    // R3: single-sample spikes inside every bit of a frame
    sendFrame(16, 1'b0, 4, "R3", 32'h96F0_1E2D);

    // R9: bit lengths varying around nominal
    sendFrame(10, 1'b1, -1, "R9", 32'hC71E_00FF);

    // R8: free-running period at 10 on a steady input
    @(negedge clk);
    rawBit = 1'b0;
    repeat (40) @(negedge clk);
    measurePeriod(10, "R8");

    // R2: pass-through
    @(negedge clk);
    recDisable = 1'b1;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      rawBit = ((i * 7) % 5) < 2;
      #1;
      check(recData == rawBit, "R2", recData, rawBit);
      check(recClk == 1'b0, "R2", recClk, 0);
    end
    @(negedge clk);
    recDisable = 1'b0;

    // R10: recovery resumes after pass-through
    sendFrame(12, 1'b0, -1, "R10", 32'h1234_ABCD);

    finishRun();
  end

endmodule